// File: doc/BRIEF.md
# Condition Code Flag Unit

This block holds the condition-code register of an 8-bit processor and the arithmetic that feeds it. Each cycle it can take two operands and a 4-bit operation code. The operation can be an addition, a subtraction, a shift or rotate, a bitwise logic operation or a packed-BCD decimal adjust. On the next clock edge the block stores the 8-bit result and the updated flags. The carry and half-carry inputs of the chained operations come from the flags the block already holds. A program can therefore add two BCD bytes and then apply the decimal adjust as the following operation.

A separate pair of controls sets or clears the interrupt mask bit. These controls work in the same cycle as an operation and do not depend on it. A small evaluator reads the stored flags and reports whether one of four signed comparison branches would be taken. Its main use is after a subtraction of two signed bytes. The sequencer, memory and other registers are outside this block.

Top module: `ccr_flag_unit`

## Requirements
- R1: After reset the result is 0x00 and the flag register reads 0x6A: mask set, zero set, all other flags clear.
- R2: Codes 0 (add) and 1 (add with carry, using the stored carry as carry-in) store a+b(+C). C is the carry out of bit 7. H is the carry out of bit 3 into bit 4. V is set on two's-complement overflow.
- R3: Codes 2 (subtract) and 3 (subtract with borrow, using the stored carry as borrow-in) store a-b(-C). C is set when a borrow is needed and V on two's-complement overflow. H is left unchanged.
- R4: For every operation that updates the register, N equals bit 7 of the result and Z is set exactly when the result is zero.
- R5: Codes 4 (shift left), 5 (arithmetic shift right, bit 7 kept), 6 (logical shift right), 7 (rotate left through C) and 8 (rotate right through C) act on operand a. C receives the bit shifted out, V becomes N XOR C, and H is left unchanged.
- R6: Codes 9 (AND), 10 (OR) and 11 (XOR) combine a and b, clear V, and leave C and H unchanged.
- R7: Code 12 is the decimal adjust of operand a. It adds 0x06 when H is set or the low nibble exceeds 9. It adds 0x60 when C is set or a exceeds 0x99, and in that case C is set, otherwise C is cleared. H and V are left unchanged. An addition of two packed-BCD bytes followed by this operation gives their decimal sum modulo 100, with C as the decimal carry.
- R8: The mask bit is set when the set control is high, even if the clear control is also high. It is cleared when only the clear control is high. No operation code changes it.
- R9: The flag register layout from bit 7 to bit 0 is V, 1, 1, H, I, N, Z, C, and bits 6 and 5 always read 1.
- R10: When the enable is low, or the code is 13, 14 or 15, the result and every flag except the mask are left unchanged.
- R11: The branch output uses the stored flags: select 0 means greater-than (not (Z or (N xor V))), 1 greater-or-equal, 2 less-or-equal and 3 less-than. After a subtraction a-b, the output equals the signed comparison of a with b.
- R12: The result and flags change on the rising clock edge after the inputs are presented. The branch output follows the stored flags and the select input without a further register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_en_i | input | 1 | Apply the operation this cycle |
| op_code_i | input | 4 | Operation code (see R2 to R7, R10) |
| opnd_a_i | input | 8 | First operand |
| opnd_b_i | input | 8 | Second operand |
| imask_set_i | input | 1 | Set the interrupt mask bit |
| imask_clr_i | input | 1 | Clear the interrupt mask bit |
| br_sel_i | input | 2 | Signed branch condition select |
| result_o | output | 8 | Stored result |
| ccr_o | output | 8 | Flag register V,1,1,H,I,N,Z,C |
| br_taken_o | output | 1 | Selected branch condition is true |

## Verification
The decimal adjust is the hardest case to reach from the ports. Its effect depends on half-carry and carry values that only an earlier addition can leave behind. The stimulus therefore pairs an addition of two packed-BCD bytes with an adjust in the next cycle, for all 100 by 100 decimal pairs. It then compares the outcome with the decimal sum. The carry-in of add-with-carry, subtract-with-borrow and the rotates also comes from the previous operation. A full operand sweep and a pseudo-random phase keep a running model of the register, so every combination of chained carry is exercised.

// File: rtl/ccr_pkg.sv
package ccr_pkg;

  localparam int unsigned DW  = 8;
  localparam int unsigned NW  = DW / 2;
  localparam int unsigned MSB = DW - 1;

  localparam logic [3:0] OP_ADD = 4'd0;
  localparam logic [3:0] OP_ADC = 4'd1;
  localparam logic [3:0] OP_SUB = 4'd2;
  localparam logic [3:0] OP_SBC = 4'd3;
  localparam logic [3:0] OP_ASL = 4'd4;
  localparam logic [3:0] OP_ASR = 4'd5;
  localparam logic [3:0] OP_LSR = 4'd6;
  localparam logic [3:0] OP_ROL = 4'd7;
  localparam logic [3:0] OP_ROR = 4'd8;
  localparam logic [3:0] OP_AND = 4'd9;
  localparam logic [3:0] OP_ORR = 4'd10;
  localparam logic [3:0] OP_XOR = 4'd11;
  localparam logic [3:0] OP_DAA = 4'd12;

  localparam logic [1:0] BR_GT = 2'd0;
  localparam logic [1:0] BR_GE = 2'd1;
  localparam logic [1:0] BR_LE = 2'd2;
  localparam logic [1:0] BR_LT = 2'd3;

  // outcome of one operation: value, new flags and which flags it writes
  typedef struct packed {
    logic [DW-1:0] res;
    logic          c;
    logic          h;
    logic          v;
    logic          wc;
    logic          wh;
    logic          wv;
    logic          hit;
  } flag_res_t;

  function automatic flag_res_t f_add(input logic [DW-1:0] a, input logic [DW-1:0] b,
                                      input logic cin);
    flag_res_t   r;
    logic [DW:0] full;
    logic [NW:0] low;
    full  = {1'b0, a} + {1'b0, b} + {{DW{1'b0}}, cin};
    low   = {1'b0, a[NW-1:0]} + {1'b0, b[NW-1:0]} + {{NW{1'b0}}, cin};
    r     = '0;
    r.res = full[DW-1:0];
    r.c   = full[DW];
    r.h   = low[NW];
    r.v   = (a[MSB] == b[MSB]) && (full[MSB] != a[MSB]);
    r.wc  = 1'b1;
    r.wh  = 1'b1;
    r.wv  = 1'b1;
    r.hit = 1'b1;
    return r;
  endfunction

  function automatic flag_res_t f_sub(input logic [DW-1:0] a, input logic [DW-1:0] b,
                                      input logic bin);
    flag_res_t   r;
    logic [DW:0] full;
    full  = {1'b0, a} - {1'b0, b} - {{DW{1'b0}}, bin};
    r     = '0;
    r.res = full[DW-1:0];
    r.c   = full[DW];
    r.v   = (a[MSB] != b[MSB]) && (full[MSB] != a[MSB]);
    r.wc  = 1'b1;
    r.wv  = 1'b1;
    r.hit = 1'b1;
    return r;
  endfunction

  // packed-BCD correction for an 8-bit accumulator
  function automatic flag_res_t f_daa(input logic [DW-1:0] a, input logic h, input logic c);
    flag_res_t     r;
    logic          hi_fix;
    logic          lo_fix;
    logic [DW-1:0] adj;
    hi_fix = c || (a > 8'h99);
    lo_fix = h || (a[NW-1:0] > 4'h9);
    adj    = {1'b0, hi_fix, hi_fix, 1'b0, 1'b0, lo_fix, lo_fix, 1'b0};
    r      = '0;
    r.res  = a + adj;
    r.c    = hi_fix;
    r.wc   = 1'b1;
    r.hit  = 1'b1;
    return r;
  endfunction

endpackage

// File: rtl/ccr_addsub.sv
module ccr_addsub
  import ccr_pkg::*;
(
  input  logic [3:0]    op_i,
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic          c_i,
  input  logic          h_i,
  output flag_res_t     out_o
);

  always_comb begin
    out_o = '0;
    case (op_i)
      OP_ADD:  out_o = f_add(a_i, b_i, 1'b0);
      OP_ADC:  out_o = f_add(a_i, b_i, c_i);
      OP_SUB:  out_o = f_sub(a_i, b_i, 1'b0);
      OP_SBC:  out_o = f_sub(a_i, b_i, c_i);
      OP_DAA:  out_o = f_daa(a_i, h_i, c_i);
      default: out_o = '0;
    endcase
  end

  // a plain subtract borrows exactly when b is the larger unsigned value
  always_comb begin
    if (op_i == OP_SUB) begin
      assert_sub_borrow_R3: assert (out_o.c == (a_i < b_i));
    end
  end

endmodule

// File: rtl/ccr_shift_logic.sv
module ccr_shift_logic
  import ccr_pkg::*;
(
  input  logic [3:0]    op_i,
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic          c_i,
  output flag_res_t     out_o
);

  logic [DW-1:0] sh_res;
  logic          sh_out;
  logic          is_sh;
  logic          is_lg;
  logic [DW-1:0] lg_res;

  always_comb begin
    sh_res = a_i;
    sh_out = 1'b0;
    is_sh  = 1'b1;
    case (op_i)
      OP_ASL: begin sh_res = {a_i[DW-2:0], 1'b0};  sh_out = a_i[MSB]; end
      OP_ASR: begin sh_res = {a_i[MSB], a_i[DW-1:1]}; sh_out = a_i[0]; end
      OP_LSR: begin sh_res = {1'b0, a_i[DW-1:1]};  sh_out = a_i[0]; end
      OP_ROL: begin sh_res = {a_i[DW-2:0], c_i};   sh_out = a_i[MSB]; end
      OP_ROR: begin sh_res = {c_i, a_i[DW-1:1]};   sh_out = a_i[0]; end
      default: is_sh = 1'b0;
    endcase
  end

  always_comb begin
    lg_res = '0;
    is_lg  = 1'b1;
    case (op_i)
      OP_AND:  lg_res = a_i & b_i;
      OP_ORR:  lg_res = a_i | b_i;
      OP_XOR:  lg_res = a_i ^ b_i;
      default: is_lg = 1'b0;
    endcase
  end

  always_comb begin
    out_o = '0;
    if (is_sh) begin
      out_o.res = sh_res;
      out_o.c   = sh_out;
      out_o.v   = sh_res[MSB] ^ sh_out;
      out_o.wc  = 1'b1;
      out_o.wv  = 1'b1;
      out_o.hit = 1'b1;
    end else if (is_lg) begin
      out_o.res = lg_res;
      out_o.wv  = 1'b1;
      out_o.hit = 1'b1;
    end
  end

endmodule

// File: rtl/ccr_branch_eval.sv
module ccr_branch_eval
  import ccr_pkg::*;
(
  input  logic [1:0] sel_i,
  input  logic       n_i,
  input  logic       z_i,
  input  logic       v_i,
  output logic       taken_o
);

  logic lt_w;
  assign lt_w = n_i ^ v_i;

  always_comb begin
    case (sel_i)
      BR_GT:   taken_o = !(z_i || lt_w);
      BR_GE:   taken_o = !lt_w;
      BR_LE:   taken_o = z_i || lt_w;
      default: taken_o = lt_w;
    endcase
  end

endmodule

// File: rtl/ccr_flag_unit.sv
module ccr_flag_unit
  import ccr_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          op_en_i,
  input  logic [3:0]    op_code_i,
  input  logic [DW-1:0] opnd_a_i,
  input  logic [DW-1:0] opnd_b_i,
  input  logic          imask_set_i,
  input  logic          imask_clr_i,
  input  logic [1:0]    br_sel_i,
  output logic [DW-1:0] result_o,
  output logic [7:0]    ccr_o,
  output logic          br_taken_o
);

  logic [DW-1:0] res_q;
  logic          v_q, h_q, i_q, n_q, z_q, c_q;

  flag_res_t arith_w;
  flag_res_t shlg_w;
  flag_res_t alu_w;
  logic      upd_w;
  logic      is_shift_w;
  logic      is_logic_w;

  ccr_addsub u_addsub (
    .op_i  (op_code_i),
    .a_i   (opnd_a_i),
    .b_i   (opnd_b_i),
    .c_i   (c_q),
    .h_i   (h_q),
    .out_o (arith_w)
  );

  ccr_shift_logic u_shlg (
    .op_i  (op_code_i),
    .a_i   (opnd_a_i),
    .b_i   (opnd_b_i),
    .c_i   (c_q),
    .out_o (shlg_w)
  );

  ccr_branch_eval u_br (
    .sel_i   (br_sel_i),
    .n_i     (n_q),
    .z_i     (z_q),
    .v_i     (v_q),
    .taken_o (br_taken_o)
  );

  assign alu_w      = arith_w.hit ? arith_w : shlg_w;
  assign upd_w      = op_en_i && alu_w.hit;
  assign is_shift_w = upd_w && (op_code_i >= OP_ASL) && (op_code_i <= OP_ROR);
  assign is_logic_w = upd_w && (op_code_i >= OP_AND) && (op_code_i <= OP_XOR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_q <= '0;
      v_q   <= 1'b0;
      h_q   <= 1'b0;
      i_q   <= 1'b1;
      n_q   <= 1'b0;
      z_q   <= 1'b1;
      c_q   <= 1'b0;
    end else begin
      if (upd_w) begin
        res_q <= alu_w.res;
        n_q   <= alu_w.res[MSB];
        z_q   <= (alu_w.res == '0);
        if (alu_w.wc) c_q <= alu_w.c;
        if (alu_w.wh) h_q <= alu_w.h;
        if (alu_w.wv) v_q <= alu_w.v;
      end
      if (imask_set_i)      i_q <= 1'b1;
      else if (imask_clr_i) i_q <= 1'b0;
    end
  end

  assign result_o = res_q;
  assign ccr_o    = {v_q, 2'b11, h_q, i_q, n_q, z_q, c_q};

  assert_zero_tracks_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    z_q == (res_q == '0));

  assert_neg_tracks_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    n_q == res_q[MSB]);

  assert_add_sum_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_w && op_code_i == OP_ADD) |=>
      ({c_q, res_q} == $past({1'b0, opnd_a_i} + {1'b0, opnd_b_i})));

  assert_shift_v_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_shift_w |=> (v_q == (n_q ^ c_q)));

  assert_logic_keeps_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_logic_w |=> (!v_q && $stable(c_q) && $stable(h_q)));

  assert_mask_set_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    imask_set_i |=> i_q);

  assert_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_w |=> ($stable(res_q) && $stable(v_q) && $stable(h_q) && $stable(c_q)));

endmodule

// File: tb/ccr_flag_unit_tb.sv
`timescale 1ns/1ps
module ccr_flag_unit_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       op_en = 1'b0;
  logic [3:0] op_code = 4'd0;
  logic [7:0] opa = 8'd0;
  logic [7:0] opb = 8'd0;
  logic       mset = 1'b0;
  logic       mclr = 1'b0;
  logic [1:0] bsel = 2'd0;
  logic [7:0] result;
  logic [7:0] ccr;
  logic       btaken;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // reference model state
  int m_res;
  bit m_v, m_h, m_i, m_n, m_z, m_c;

  always #10 clk = ~clk;

  ccr_flag_unit dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .op_en_i     (op_en),
    .op_code_i   (op_code),
    .opnd_a_i    (opa),
    .opnd_b_i    (opb),
    .imask_set_i (mset),
    .imask_clr_i (mclr),
    .br_sel_i    (bsel),
    .result_o    (result),
    .ccr_o       (ccr),
    .br_taken_o  (btaken)
  );

  function automatic int sgn(input int x);
    return (x >= 128) ? x - 256 : x;
  endfunction

  function automatic string tag_for(input int op);
    if (op <= 1)  return "R2";
    if (op <= 3)  return "R3";
    if (op <= 8)  return "R5";
    if (op <= 11) return "R6";
    if (op == 12) return "R7";
    return "R10";
  endfunction

  task automatic model_step(input bit en, input int op, input int a, input int b,
                            input bit st, input bit cl);
    int r;
    int s;
    bit hi;
    bit lo;
    if (en && op <= 12) begin
      case (op)
        0, 1: begin
          r   = a + b + ((op == 1) ? int'(m_c) : 0);
          s   = sgn(a) + sgn(b) + ((op == 1) ? int'(m_c) : 0);
          m_h = ((a % 16) + (b % 16) + ((op == 1) ? int'(m_c) : 0)) > 15;
          m_c = r > 255;
          m_v = (s > 127) || (s < -128);
          r   = r % 256;
        end
        2, 3: begin
          r   = a - b - ((op == 3) ? int'(m_c) : 0);
          s   = sgn(a) - sgn(b) - ((op == 3) ? int'(m_c) : 0);
          m_c = r < 0;
          m_v = (s > 127) || (s < -128);
          r   = (r + 512) % 256;
        end
        4: begin r = (a * 2) % 256; m_c = a >= 128; end
        5: begin r = a / 2 + ((a >= 128) ? 128 : 0); m_c = (a % 2) == 1; end
        6: begin r = a / 2; m_c = (a % 2) == 1; end
        7: begin r = (a * 2) % 256 + int'(m_c); m_c = a >= 128; end
        8: begin r = a / 2 + (m_c ? 128 : 0); m_c = (a % 2) == 1; end
        9:  begin r = a & b; m_v = 1'b0; end
        10: begin r = a | b; m_v = 1'b0; end
        11: begin r = a ^ b; m_v = 1'b0; end
        default: begin
          lo  = m_h || ((a % 16) > 9);
          hi  = m_c || (a > 153);
          r   = (a + (hi ? 96 : 0) + (lo ? 6 : 0)) % 256;
          m_c = hi;
        end
      endcase
      if (op >= 4 && op <= 8) m_v = (r >= 128) ^ m_c;
      m_res = r;
      m_n   = r >= 128;
      m_z   = r == 0;
    end
    if (st)      m_i = 1'b1;
    else if (cl) m_i = 1'b0;
  endtask

  function automatic logic [7:0] exp_ccr();
    return {m_v, 1'b1, 1'b1, m_h, m_i, m_n, m_z, m_c};
  endfunction

  // drive at the falling edge, let the rising edge register, compare at the next falling edge (R12)
  task automatic step(input bit en, input int op, input int a, input int b,
                      input bit st, input bit cl, input int br);
    logic [7:0] e;
    logic [7:0] d;
    string      t;
    op_en   = en;
    op_code = op[3:0];
    opa     = a[7:0];
    opb     = b[7:0];
    mset    = st;
    mclr    = cl;
    bsel    = br[1:0];
    @(posedge clk);
    model_step(en, op, a, b, st, cl);
    @(negedge clk);
    e = exp_ccr();
    checks++;
    if (result !== m_res[7:0] || ccr !== e) begin
      d = ccr ^ e;
      if (d[3])                  t = "R8";
      else if (d[6] || d[5])     t = "R9";
      else if (result === m_res[7:0] && (d[2] || d[1])) t = "R4";
      else if (!en)              t = "R10";
      else                       t = tag_for(op);
      fails++;
      $display("FAIL %s op=%0d a=%02h b=%02h: result=%02h ccr=%02h expected result=%02h ccr=%02h",
               t, op, a, b, result, ccr, m_res[7:0], e);
    end
  endtask

  function automatic bit br_exp(input int sel, input int sa, input int sb);
    case (sel)
      0:       return sa > sb;
      1:       return sa >= sb;
      2:       return sa <= sb;
      default: return sa < sb;
    endcase
  endfunction

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    bit [31:0] rng;
    m_res = 0; m_v = 0; m_h = 0; m_i = 1; m_n = 0; m_z = 1; m_c = 0;
    repeat (3) @(negedge clk);
    // R1: reset values, still in reset
    checks++;
    if (result !== 8'h00 || ccr !== 8'h6A) begin
      fails++;
      $display("FAIL R1 reset: result=%02h ccr=%02h expected result=00 ccr=6A", result, ccr);
    end
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (result !== 8'h00 || ccr !== 8'h6A) begin
      fails++;
      $display("FAIL R1 after release: result=%02h ccr=%02h expected result=00 ccr=6A", result, ccr);
    end

    // R8: set wins over clear, clear alone clears, then set again
    step(1'b0, 0, 0, 0, 1'b1, 1'b1, 0);
    step(1'b0, 0, 0, 0, 1'b0, 1'b1, 0);
    step(1'b0, 0, 0, 0, 1'b1, 1'b0, 0);
    step(1'b0, 0, 0, 0, 1'b0, 1'b1, 0);

    // R2..R7, R10: every code, all a, spread of b, chained carry from the model
    for (int op = 0; op < 16; op++)
      for (int a = 0; a < 256; a++)
        for (int b = 0; b < 256; b += 17)
          step(1'b1, op, a, b, 1'b0, 1'b0, 0);

    // R7: BCD addition followed by decimal adjust, all decimal pairs
    for (int x = 0; x < 100; x++)
      for (int y = 0; y < 100; y++) begin
        int bx;
        int by;
        int want;
        bx = (x / 10) * 16 + (x % 10);
        by = (y / 10) * 16 + (y % 10);
        step(1'b1, 0, bx, by, 1'b0, 1'b0, 0);
        step(1'b1, 12, result, 0, 1'b0, 1'b0, 0);
        want = ((x + y) % 100 / 10) * 16 + ((x + y) % 10);
        checks++;
        if (result !== want[7:0] || ccr[0] !== ((x + y) >= 100)) begin
          fails++;
          $display("FAIL R7 bcd %0d+%0d: result=%02h C=%0b expected result=%02h C=%0b",
                   x, y, result, ccr[0], want[7:0], (x + y) >= 100);
        end
      end

    // R11: signed compare after subtract, all four selects
    for (int a = 0; a < 256; a++)
      for (int b = 0; b < 256; b += 3) begin
        int sel;
        bit want;
        sel = (a + b) % 4;
        step(1'b1, 2, a, b, 1'b0, 1'b0, sel);
        want = br_exp(sel, sgn(a), sgn(b));
        checks++;
        if (btaken !== want) begin
          fails++;
          $display("FAIL R11 sel=%0d a=%02h b=%02h: taken=%0b expected=%0b",
                   sel, a, b, btaken, want);
        end
      end

    // R8, R10 and chaining: pseudo-random mix including disabled steps and mask traffic
    rng = 32'h1234_5678;
    for (int k = 0; k < 6000; k++) begin
      rng = rng ^ (rng << 13);
      rng = rng ^ (rng >> 17);
      rng = rng ^ (rng << 5);
      step(rng[31:29] != 3'd0, int'(rng[3:0]), int'(rng[11:4]), int'(rng[19:12]),
           rng[20] & rng[21], rng[22] & rng[23], int'(rng[25:24]));
    end

    done = 1'b1;
    finish_run();
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R12 watchdog: run=hung expected=finished");
      finish_run();
    end
  end

endmodule